// File: doc/BRIEF.md
# Trigger Input Statistics Counter Bank

This block collects run-time statistics for a trigger controller. It watches a set of synchronous trigger inputs, one combined trigger line, an accept strobe and a busy flag that marks dead time. For every input it keeps two counters: one for the cycles the input is high and one for its rising edges. It also keeps counters for the combined trigger (cycles high, rising edges, accepts), counters for idle cycles and dead cycles, the dead time of the most recent trigger, a free-running timestamp, and a bitmask of the inputs taken at the moment of acceptance.

Each accept strobe copies every value into a snapshot bank. Readout logic fetches words from that bank through an indexed read port, so all words it reads come from the same trigger. The live counters keep running between accepts and cannot be read directly.

Word map, with N = `NUM_IN`: word 2i is the level counter of input i and word 2i+1 is its edge counter. Word 2N holds trigger cycles, 2N+1 trigger edges, 2N+2 accepts, 2N+3 idle cycles, 2N+4 dead cycles, 2N+5 last dead time, 2N+6 timestamp and 2N+7 the input bitmask.

Top module: `trig_stat_bank`

## Requirements
- R1: After reset all live counters, the timestamp and the snapshot words read as zero, except the last-dead-time word, which reads all ones. `rd_valid_o` is low.
- R2: Word 2i counts the clock cycles in which `in_i[i]` is high, modulo 2^CW.
- R3: Word 2i+1 counts rising edges of `in_i[i]`, meaning the input is high in a cycle after being low in the previous one. An input already high when reset is released is not counted as an edge.
- R4: The level and edge counters of one input wrap around independently. Neither saturates and neither clears the other.
- R5: Word 2N counts cycles with `trig_i` high, word 2N+1 counts rising edges of `trig_i` under the rule of R3, and word 2N+2 counts cycles with `accept_i` high.
- R6: Word 2N+3 counts cycles with `busy_i` low and word 2N+4 counts cycles with `busy_i` high, so exactly one of the two advances every cycle.
- R7: Word 2N+5 holds the number of cycles with `busy_i` high that follow an accept cycle, up to the first cycle with `busy_i` low. It is written in that busy-low cycle. It reads all ones until the first measurement completes, and a new accept restarts the measurement.
- R8: Word 2N+6 is a timestamp that advances by one every cycle and wraps. The snapshot keeps its value from the accept cycle.
- R9: Word 2N+7 holds `in_i` as sampled in the accept cycle, with bit i taken from input i and zero-extended to CW bits.
- R10: In an accept cycle the snapshot takes every counter with that cycle's increment included, and it takes the last-dead-time value from before that cycle. Reads return only snapshot words, and those words do not change between accepts.
- R11: A request made with `rd_en_i` high returns the addressed word on `rd_data_o` in the next cycle, with `rd_valid_o` high for that one cycle. Indices of 2N+8 and above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | NUM_IN | Synchronous trigger inputs |
| trig_i | input | 1 | Combined trigger |
| accept_i | input | 1 | Trigger accept strobe; loads the snapshot |
| busy_i | input | 1 | Dead-time indication |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | clog2(2*NUM_IN+8) | Word index |
| rd_data_o | output | CW | Snapshot word |
| rd_valid_o | output | 1 | Read data valid |

## Verification
Some properties are checked on every cycle: the per-cycle increments of the level, accept, dead and timestamp counters; that the edge counters stay still while their input is low or held high; that idle and dead time split every cycle between them; that the last-dead-time register holds outside a busy fall; that the snapshot holds between accepts and that the mask is captured on an accept; and the one-cycle read valid. Other behaviour only the bench scenarios can show: the full contents of the snapshot after random trigger traffic, the directed dead-time value, an input held high from reset, wrap-around on a narrow counter instance, the reset contents and reads beyond the word map.

// File: rtl/trig_stat_pkg.sv
package trig_stat_pkg;
  // word offsets after the per-input pairs
  typedef enum int {
    G_TRIG_LVL  = 0,
    G_TRIG_EDG  = 1,
    G_ACCEPT    = 2,
    G_IDLE      = 3,
    G_DEAD      = 4,
    G_LAST_DEAD = 5,
    G_TSTAMP    = 6,
    G_MASK      = 7,
    G_NUM       = 8
  } glob_e;

  function automatic int stat_words(input int n);
    return 2 * n + G_NUM;
  endfunction
endpackage

// File: rtl/edge_det.sv
module edge_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= sig_i;
      armed_q <= 1'b1;
    end
  end

  // first cycle out of reset never reports an edge
  assign rise_o = {W{armed_q}} & sig_i & ~prev_q;
endmodule

// File: rtl/stat_ctr.sv
module stat_ctr #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] q_o,
  output logic [CW-1:0] d_o
);
  logic [CW-1:0] cnt_q;

  assign d_o = cnt_q + {{(CW-1){1'b0}}, inc_i};
  assign q_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= d_o;
  end
endmodule

// File: rtl/dead_meter.sv
module dead_meter #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          busy_i,
  output logic [CW-1:0] last_o,
  output logic          active_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] meas_q, last_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meas_q   <= '0;
      last_q   <= '1;
      active_q <= 1'b0;
    end else begin
      if (active_q && !busy_i) last_q <= meas_q;
      if (accept_i) begin
        active_q <= 1'b1;
        meas_q   <= '0;
      end else if (active_q) begin
        if (busy_i) meas_q   <= meas_q + ONE;
        else        active_q <= 1'b0;
      end
    end
  end

  assign last_o   = last_q;
  assign active_o = active_q;
endmodule

// File: rtl/trig_stat_bank.sv
module trig_stat_bank
  import trig_stat_pkg::*;
#(
  parameter int NUM_IN = 16,
  parameter int CW = 32,
  localparam int NW = stat_words(NUM_IN),
  localparam int IDXW = $clog2(NW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] in_i,
  input  logic              trig_i,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic              rd_en_i,
  input  logic [IDXW-1:0]   rd_idx_i,
  output logic [CW-1:0]     rd_data_o,
  output logic              rd_valid_o
);
  localparam int BASE = 2 * NUM_IN;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [NUM_IN:0]              rise;
  logic [NUM_IN-1:0][CW-1:0]    lvl_q, lvl_d, edg_q, edg_d;
  logic [CW-1:0] tlvl_q, tlvl_d, tedg_q, tedg_d, acc_q, acc_d;
  logic [CW-1:0] idle_q, idle_d, dead_q, dead_d;
  logic [CW-1:0] ts_q, last_q;
  logic          meas_active;
  logic [NW-1:0][CW-1:0] live_w, snap_q;
  logic [CW-1:0] snap_ts_w, snap_mask_w;
  logic [CW-1:0] rd_data_q;
  logic          rd_valid_q;

  edge_det #(.W(NUM_IN + 1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({trig_i, in_i}),
    .rise_o (rise)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    stat_ctr #(.CW(CW)) u_lvl (
      .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (in_i[i]),
      .q_o (lvl_q[i]), .d_o (lvl_d[i])
    );
    stat_ctr #(.CW(CW)) u_edg (
      .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (rise[i]),
      .q_o (edg_q[i]), .d_o (edg_d[i])
    );
  end

  stat_ctr #(.CW(CW)) u_tlvl (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (trig_i),
    .q_o (tlvl_q), .d_o (tlvl_d)
  );
  stat_ctr #(.CW(CW)) u_tedg (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (rise[NUM_IN]),
    .q_o (tedg_q), .d_o (tedg_d)
  );
  stat_ctr #(.CW(CW)) u_acc (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (accept_i),
    .q_o (acc_q), .d_o (acc_d)
  );
  stat_ctr #(.CW(CW)) u_idle (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (~busy_i),
    .q_o (idle_q), .d_o (idle_d)
  );
  stat_ctr #(.CW(CW)) u_dead (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (busy_i),
    .q_o (dead_q), .d_o (dead_d)
  );

  dead_meter #(.CW(CW)) u_dm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept_i),
    .busy_i   (busy_i),
    .last_o   (last_q),
    .active_o (meas_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + ONE;
  end

  // snapshot source: counters include the current cycle
  always_comb begin
    live_w = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      live_w[2*i]   = lvl_d[i];
      live_w[2*i+1] = edg_d[i];
    end
    live_w[BASE+G_TRIG_LVL]          = tlvl_d;
    live_w[BASE+G_TRIG_EDG]          = tedg_d;
    live_w[BASE+G_ACCEPT]            = acc_d;
    live_w[BASE+G_IDLE]              = idle_d;
    live_w[BASE+G_DEAD]              = dead_d;
    live_w[BASE+G_LAST_DEAD]         = last_q;
    live_w[BASE+G_TSTAMP]            = ts_q;
    live_w[BASE+G_MASK][NUM_IN-1:0]  = in_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q                   <= '0;
      snap_q[BASE+G_LAST_DEAD] <= '1;
    end else if (accept_i) begin
      snap_q <= live_w;
    end
  end

  assign snap_ts_w   = snap_q[BASE+G_TSTAMP];
  assign snap_mask_w = snap_q[BASE+G_MASK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= (int'(rd_idx_i) < NW) ? snap_q[rd_idx_i] : '0;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/trig_stat_bank_chk.sv
module trig_stat_bank_chk #(
  parameter int NUM_IN = 16,
  parameter int CW = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_IN-1:0]         in_i,
  input logic                      accept_i,
  input logic                      busy_i,
  input logic                      rd_en_i,
  input logic                      rd_valid_o,
  input logic [NUM_IN-1:0][CW-1:0] lvl_q,
  input logic [NUM_IN-1:0][CW-1:0] edg_q,
  input logic [CW-1:0]             acc_q,
  input logic [CW-1:0]             idle_q,
  input logic [CW-1:0]             dead_q,
  input logic [CW-1:0]             ts_q,
  input logic [CW-1:0]             last_q,
  input logic                      meas_active,
  input logic [CW-1:0]             snap_ts,
  input logic [CW-1:0]             snap_mask
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] tot;
  assign tot = idle_q + dead_q;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_chk
    p_level_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_i[g] |=> lvl_q[g] == $past(lvl_q[g]) + ONE);
    p_level_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_i[g] |=> $stable(lvl_q[g]));
    p_edge_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_i[g] |=> $stable(edg_q[g]));
    p_edge_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_i[g] && $past(in_i[g])) |=> $stable(edg_q[g]));
  end

  p_accept_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> acc_q == $past(acc_q) + ONE);
  p_accept_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(acc_q));
  p_dead_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> dead_q == $past(dead_q) + ONE);
  p_split_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> tot == $past(tot) + ONE);
  p_last_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(meas_active && !busy_i) |=> $stable(last_q));
  p_ts_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ts_q == $past(ts_q) + ONE);
  p_mask_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> snap_mask[NUM_IN-1:0] == $past(in_i));
  p_snap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($stable(snap_ts) && $stable(snap_mask)));
  p_rd_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  p_rd_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind trig_stat_bank trig_stat_bank_chk #(.NUM_IN(NUM_IN), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_i        (in_i),
  .accept_i    (accept_i),
  .busy_i      (busy_i),
  .rd_en_i     (rd_en_i),
  .rd_valid_o  (rd_valid_o),
  .lvl_q       (lvl_q),
  .edg_q       (edg_q),
  .acc_q       (acc_q),
  .idle_q      (idle_q),
  .dead_q      (dead_q),
  .ts_q        (ts_q),
  .last_q      (last_q),
  .meas_active (meas_active),
  .snap_ts     (snap_ts_w),
  .snap_mask   (snap_mask_w)
);

// File: tb/trig_stat_bank_test.sv
module trig_stat_bank_test;
  localparam int N = 16;
  localparam int NW = 2 * N + 8;
  localparam int B = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] in_r = '0;
  logic trig_r = 1'b0, acc_r = 1'b0, busy_r = 1'b0, rd_en = 1'b0;
  logic [5:0] rd_idx = '0;
  logic [31:0] rd_data;
  logic rd_valid;

  logic [1:0] n_in = '0;
  logic n_acc = 1'b0, n_rd_en = 1'b0;
  logic [3:0] n_idx = '0;
  logic [7:0] n_data;
  logic n_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trig_stat_bank uut (
    .clk_i (clk), .rst_ni (rst_n), .in_i (in_r), .trig_i (trig_r),
    .accept_i (acc_r), .busy_i (busy_r), .rd_en_i (rd_en), .rd_idx_i (rd_idx),
    .rd_data_o (rd_data), .rd_valid_o (rd_valid)
  );

  trig_stat_bank #(.NUM_IN(2), .CW(8)) uut_narrow (
    .clk_i (clk), .rst_ni (rst_n), .in_i (n_in), .trig_i (1'b0),
    .accept_i (n_acc), .busy_i (1'b0), .rd_en_i (n_rd_en), .rd_idx_i (n_idx),
    .rd_data_o (n_data), .rd_valid_o (n_valid)
  );

  // reference model
  logic [31:0] m_lvl [N];
  logic [31:0] m_edg [N];
  logic [31:0] m_snap [NW];
  logic [N-1:0] m_prev;
  logic m_tprev, m_armed, m_active;
  logic [31:0] m_ta, m_te, m_tacc, m_idle, m_dead, m_ts, m_last, m_meas;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_edg[i] = 0; end
    for (int i = 0; i < NW; i++) m_snap[i] = 0;
    m_snap[B+5] = 32'hFFFF_FFFF;
    m_prev = '0; m_tprev = 0; m_armed = 0; m_active = 0;
    m_ta = 0; m_te = 0; m_tacc = 0; m_idle = 0; m_dead = 0; m_ts = 0;
    m_last = 32'hFFFF_FFFF; m_meas = 0;
  endtask

  task automatic model_update();
    logic [N-1:0] rise;
    rise = {N{m_armed}} & in_r & ~m_prev;
    for (int i = 0; i < N; i++) begin
      m_lvl[i] += 32'(in_r[i]);
      m_edg[i] += 32'(rise[i]);
    end
    m_ta += 32'(trig_r);
    m_te += 32'(m_armed & trig_r & ~m_tprev);
    m_tacc += 32'(acc_r);
    m_idle += 32'(!busy_r);
    m_dead += 32'(busy_r);
    if (acc_r) begin
      for (int i = 0; i < N; i++) begin
        m_snap[2*i] = m_lvl[i];
        m_snap[2*i+1] = m_edg[i];
      end
      m_snap[B] = m_ta; m_snap[B+1] = m_te; m_snap[B+2] = m_tacc;
      m_snap[B+3] = m_idle; m_snap[B+4] = m_dead; m_snap[B+5] = m_last;
      m_snap[B+6] = m_ts; m_snap[B+7] = 32'(in_r);
    end
    if (m_active && !busy_r) m_last = m_meas;
    if (acc_r) begin m_active = 1; m_meas = 0; end
    else if (m_active) begin
      if (busy_r) m_meas += 1;
      else m_active = 0;
    end
    m_prev = in_r; m_tprev = trig_r; m_armed = 1; m_ts += 1;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int idx);
    if (idx < B) return (idx % 2 == 0) ? "R2 level word" : "R3 edge word";
    case (idx - B)
      0, 1, 2: return "R5 trigger word";
      3, 4:    return "R6 idle/dead word";
      5:       return "R7 last dead word";
      6:       return "R8 timestamp word";
      default: return "R9 mask word";
    endcase
  endfunction

  task automatic rd_word(int idx, output logic [31:0] val);
    rd_en = 1; rd_idx = 6'(idx);
    step();
    rd_en = 0;
    val = rd_data;
    chk("R11 valid on read", {31'b0, rd_valid}, 32'd1);
  endtask

  task automatic read_all(string ctx);
    logic [31:0] v;
    for (int i = 0; i < NW; i++) begin
      rd_word(i, v);
      chk({ctx, " R10 ", tag_of(i)}, v, m_snap[i]);
    end
  endtask

  task automatic rand_in();
    in_r = N'($urandom);
    trig_r = ($urandom_range(0, 3) == 0);
  endtask

  task automatic fire(int d, bit rnd);
    acc_r = 1; busy_r = 0;
    if (rnd) rand_in();
    step();
    acc_r = 0; busy_r = 1;
    for (int k = 0; k < d; k++) begin
      if (rnd) rand_in();
      step();
    end
    busy_r = 0;
    step();
  endtask

  task automatic n_read(int idx, output logic [7:0] val);
    n_rd_en = 1; n_idx = 4'(idx);
    step();
    n_rd_en = 0;
    val = n_data;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v1;
    logic [7:0] nv;
    void'($urandom(32'd2024));
    in_r = 16'h0008;  // input 3 high through reset
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    chk("R1 rd_valid low after reset", {31'b0, rd_valid}, 32'd0);
    read_all("R1 reset contents");

    // input held high from reset: no edge
    repeat (5) step();
    fire(0, 0);
    rd_word(7, v);
    chk("R3 held-from-reset input no edge", v, 32'd0);
    rd_word(6, v);
    chk("R2 level of held input", v, m_snap[6]);

    // directed dead time
    in_r = '0;
    fire(5, 0);
    repeat (3) step();
    fire(0, 0);
    rd_word(B + 5, v);
    chk("R7 dead time of previous trigger", v, 32'd5);

    // snapshot holds between accepts
    rd_word(B + 6, v1);
    for (int k = 0; k < 20; k++) begin rand_in(); busy_r = k[0]; step(); end
    busy_r = 0;
    rd_word(B + 6, v);
    chk("R10 snapshot unchanged without accept", v, v1);
    rd_word(B + 7, v);
    chk("R10 mask unchanged without accept", v, m_snap[B+7]);

    // out-of-range indices and valid drop
    rd_word(45, v);
    chk("R11 out-of-range index 45", v, 32'd0);
    rd_word(63, v);
    chk("R11 out-of-range index 63", v, 32'd0);
    step();
    chk("R11 valid drops without request", {31'b0, rd_valid}, 32'd0);

    // independent wrap on a narrow instance
    for (int k = 1; k <= 300; k++) begin
      n_in = {k[0], 1'b1};
      n_acc = (k == 300);
      step();
    end
    n_acc = 0; n_in = '0;
    n_read(0, nv);
    chk("R4 level wraps (300 mod 256)", 32'(nv), 32'd44);
    n_read(1, nv);
    chk("R4 edge counter independent of level wrap", 32'(nv), 32'd1);
    n_read(2, nv);
    chk("R2 toggling input level", 32'(nv), 32'd150);
    n_read(3, nv);
    chk("R3 toggling input edges", 32'(nv), 32'd150);

    // random traffic
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < $urandom_range(3, 25); k++) begin rand_in(); step(); end
      fire($urandom_range(0, 15), 1);
      if (t % 10 == 9) read_all("random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule